// File: doc/BRIEF.md
# Memory-Mapped I/O Address Control

This block sits between the address register of a small 16-bit processor and the storage behind it. On every cycle in which the processor asks for a memory or I/O access, the block examines the 16-bit address. It then decides whether the access belongs to main memory or to one of the device registers that occupy the top of the address space. Main memory only covers the low part of the 64K space, from x0000 up to xFDFF. From xFE00 upward, the memory enable is withheld and the access is steered to a device register instead. A read returns that register's contents. A write loads the register, so ordinary load and store operations serve as input and output.

Four device registers are held in the block as plain storage so that decoding can be observed end to end: keyboard status, keyboard data, display status and display data. The read-data multiplexer passes either the data returned by external memory or the contents of the selected register. Decoding is combinational within the access cycle, and a register write takes effect at the next rising clock edge.

Top module: `mmio_addr_ctrl`

## Requirements
- R1: With `accEn`=1, `memEn` is 1 exactly when `addr` is at most xFDFF, for reads and writes alike; it is never 1 for an address of xFE00 or above.
- R2: With `accEn`=0, `memEn` is 0, every bit of `devLoad` is 0, `rdSel` holds the memory code 0, and no device register changes.
- R3: A write (`wrSel`=1, `accEn`=1) to a device address raises only the matching `devLoad` bit and keeps `memEn` at 0. Bit 0 is xFE00 (keyboard status), bit 1 is xFE02 (keyboard data), bit 2 is xFE04 (display status) and bit 3 is xFE06 (display data).
- R4: A read (`wrSel`=0, `accEn`=1) of a device address sets `rdSel` to the device bit index plus 1 (codes 1 to 4), places that register's contents on `rdData`, and raises no `devLoad` bit.
- R5: After a write to a device address, that register holds `wrData` from the next clock edge onward, and the other three registers keep their values.
- R6: Any address from xFE00 to xFFFF that is not one of the four device addresses (including odd addresses such as xFE01) gives `memEn`=0 and `devLoad`=0. It sets `rdSel` to code 5 and returns x0000 on `rdData`.
- R7: After reset, every device register reads x0000.
- R8: A read of a memory-range address sets `rdSel` to 0 and passes `memRdData` to `rdData` unchanged.
- R9: The boundary is exact: xFDFF is memory, and xFE00 is the keyboard status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; device registers load on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| accEn | input | 1 | Memory/I/O access request for this cycle |
| wrSel | input | 1 | 1 selects a write (store), 0 selects a read (load) |
| addr | input | 16 | Address register value |
| wrData | input | 16 | Data to be written |
| memRdData | input | 16 | Data returned by main memory |
| memEn | output | 1 | Enables the main memory array |
| devLoad | output | 4 | Per-register load enables, one bit per device register |
| rdSel | output | 3 | Read multiplexer code: 0 memory, 1 to 4 device, 5 unmapped |
| rdData | output | 16 | Data returned to the processor |

## Verification
The assertions assume that `accEn`, `wrSel`, `addr` and `wrData` change only between clock edges. They also assume that each access is held stable for the whole cycle in which it is decoded. Under those assumptions, a load strobe seen at an edge belongs to exactly one write. The stimulus changes inputs only at the falling edge and presents each access for one full cycle. It sweeps every address as a read and as a write, plus a strided set with the access request low.

// File: rtl/mmio_pkg.sv
package mmio_pkg;
  localparam int MMIO_NUM_DEV = 4;
  localparam int MMIO_SEL_W   = $clog2(MMIO_NUM_DEV + 2);

  localparam logic [MMIO_SEL_W-1:0] SEL_MEM  = '0;
  localparam logic [MMIO_SEL_W-1:0] SEL_NONE = MMIO_SEL_W'(MMIO_NUM_DEV + 1);

  typedef struct packed {
    logic                      memEn;
    logic [MMIO_NUM_DEV-1:0]   devLoad;
    logic [MMIO_SEL_W-1:0]     rdSel;
  } ctrlStrobes_t;
endpackage

// File: rtl/mmio_ctrl.sv
module mmio_ctrl
  import mmio_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int IO_BASE    = 'hFE00,
  parameter int DEV_STRIDE = 2
) (
  input  logic              accEn,
  input  logic              wrSel,
  input  logic [ADDR_W-1:0] addr,
  output ctrlStrobes_t      strobes
);
  localparam logic [ADDR_W-1:0] IO_BASE_A = ADDR_W'(IO_BASE);

  logic inMemRange;
  logic [MMIO_NUM_DEV-1:0] devHit;

  assign inMemRange = (addr < IO_BASE_A);

  // one exact-address comparator per device register
  for (genvar g = 0; g < MMIO_NUM_DEV; g++) begin : g_hit
    localparam logic [ADDR_W-1:0] DEV_ADDR = ADDR_W'(IO_BASE + g * DEV_STRIDE);
    assign devHit[g] = (addr == DEV_ADDR);
  end

  always_comb begin
    strobes       = '0;
    strobes.rdSel = SEL_MEM;
    if (accEn) begin
      if (inMemRange) begin
        strobes.memEn = 1'b1;
      end else begin
        strobes.rdSel = SEL_NONE;
        for (int i = 0; i < MMIO_NUM_DEV; i++) begin
          if (devHit[i]) begin
            strobes.rdSel      = MMIO_SEL_W'(i + 1);
            strobes.devLoad[i] = wrSel;
          end
        end
      end
    end
  end
endmodule

// File: rtl/mmio_regs.sv
module mmio_regs
  import mmio_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] memRdData,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] regQ [MMIO_NUM_DEV];

  for (genvar g = 0; g < MMIO_NUM_DEV; g++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 regQ[g] <= '0;
      else if (strobes.devLoad[g]) regQ[g] <= wrData;
    end
  end

  always_comb begin
    rdData = '0;
    if (strobes.rdSel == SEL_MEM) begin
      rdData = memRdData;
    end else begin
      for (int i = 0; i < MMIO_NUM_DEV; i++) begin
        if (strobes.rdSel == MMIO_SEL_W'(i + 1)) rdData = regQ[i];
      end
    end
  end
endmodule

// File: rtl/mmio_addr_ctrl.sv
module mmio_addr_ctrl
  import mmio_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16,
  parameter int IO_BASE    = 'hFE00,
  parameter int DEV_STRIDE = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    accEn,
  input  logic                    wrSel,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [DATA_W-1:0]       wrData,
  input  logic [DATA_W-1:0]       memRdData,
  output logic                    memEn,
  output logic [MMIO_NUM_DEV-1:0] devLoad,
  output logic [MMIO_SEL_W-1:0]   rdSel,
  output logic [DATA_W-1:0]       rdData
);
  ctrlStrobes_t strobes;

  mmio_ctrl #(
    .ADDR_W(ADDR_W), .IO_BASE(IO_BASE), .DEV_STRIDE(DEV_STRIDE)
  ) u_ctrl (
    .accEn(accEn), .wrSel(wrSel), .addr(addr), .strobes(strobes)
  );

  mmio_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .wrData(wrData), .memRdData(memRdData), .rdData(rdData)
  );

  assign memEn   = strobes.memEn;
  assign devLoad = strobes.devLoad;
  assign rdSel   = strobes.rdSel;
endmodule

// File: rtl/mmio_chk.sv
module mmio_chk
  import mmio_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int IO_BASE = 'hFE00
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    accEn,
  input logic                    wrSel,
  input logic [ADDR_W-1:0]       addr,
  input logic                    memEn,
  input logic [MMIO_NUM_DEV-1:0] devLoad,
  input logic [MMIO_SEL_W-1:0]   rdSel,
  input logic [DATA_W-1:0]       rdData
);
  p_memen_range_r1: assert property (@(posedge clk) disable iff (!rstN)
    memEn |-> (accEn && addr < ADDR_W'(IO_BASE)));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !accEn |-> (!memEn && devLoad == '0 && rdSel == SEL_MEM));

  p_load_onehot_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(devLoad));

  p_load_not_mem_r3: assert property (@(posedge clk) disable iff (!rstN)
    (devLoad != '0) |-> (!memEn && wrSel && accEn));

  p_read_no_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    (accEn && !wrSel) |-> (devLoad == '0));

  p_unmapped_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rdSel == SEL_NONE) |-> (rdData == '0 && !memEn && devLoad == '0));
endmodule

bind mmio_addr_ctrl mmio_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IO_BASE(IO_BASE)
) u_chk (
  .clk(clk), .rstN(rstN), .accEn(accEn), .wrSel(wrSel), .addr(addr),
  .memEn(memEn), .devLoad(devLoad), .rdSel(rdSel), .rdData(rdData)
);

// File: tb/sim_mmio_addr_ctrl.sv
`timescale 1ns/1ps
module sim_mmio_addr_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accEn = 1'b0;
  logic        wrSel = 1'b0;
  logic [15:0] addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] memRdData;
  logic        memEn;
  logic [3:0]  devLoad;
  logic [2:0]  rdSel;
  logic [15:0] rdData;

  int checks = 0;
  int errors = 0;
  logic [15:0] model [4];

  always #2 clk = ~clk;
  assign memRdData = ~addr;

  mmio_addr_ctrl u0 (
    .clk(clk), .rstN(rstN), .accEn(accEn), .wrSel(wrSel), .addr(addr),
    .wrData(wrData), .memRdData(memRdData), .memEn(memEn),
    .devLoad(devLoad), .rdSel(rdSel), .rdData(rdData)
  );

  function automatic int devIndex(input logic [15:0] a);
    int off;
    if (a < 16'hFE00 || a[0]) return -1;
    off = (int'(a) - 'hFE00) / 2;
    return (off < 4) ? off : -1;
  endfunction

  task automatic access(input logic en, input logic wr, input logic [15:0] a,
                        input logic [15:0] d);
    int di;
    logic       eMem;
    logic [3:0] eLoad;
    logic [2:0] eSel;
    logic [15:0] eData;
    string tag;
    @(negedge clk);
    accEn = en; wrSel = wr; addr = a; wrData = d;
    #1;
    di    = devIndex(a);
    eMem  = en && (a < 16'hFE00);
    eLoad = (en && wr && di >= 0) ? 4'(1 << di) : 4'h0;
    if (!en || a < 16'hFE00) eSel = 3'd0;
    else if (di >= 0)        eSel = 3'(di + 1);
    else                     eSel = 3'd5;
    if (eSel == 3'd0)      eData = ~a;
    else if (di >= 0)      eData = model[di];
    else                   eData = 16'h0000;
    if (!en)                           tag = "R2";
    else if (a == 16'hFDFF || a == 16'hFE00) tag = "R9";
    else if (a < 16'hFE00)             tag = wr ? "R1" : "R8";
    else if (di >= 0)                  tag = wr ? "R3" : "R4";
    else                               tag = "R6";
    checks++;
    if (memEn !== eMem || devLoad !== eLoad || rdSel !== eSel ||
        (!wr && rdData !== eData)) begin
      errors++;
      $display("FAIL %s addr=%h en=%b wr=%b: memEn=%b devLoad=%b rdSel=%0d rdData=%h expected memEn=%b devLoad=%b rdSel=%0d rdData=%h",
               tag, a, en, wr, memEn, devLoad, rdSel, rdData, eMem, eLoad, eSel, eData);
    end
    if (en && wr && di >= 0) model[di] = d;
  endtask

  task automatic readBack(input string tag);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      accEn = 1'b1; wrSel = 1'b0; addr = 16'(16'hFE00 + 2 * i);
      #1;
      checks++;
      if (rdData !== model[i]) begin
        errors++;
        $display("FAIL %s reg%0d: rdData=%h expected %h", tag, i, rdData, model[i]);
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) model[i] = 16'h0000;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    // R7: registers clear after reset
    readBack("R7");
    // R1 R6 R8 R9 R4: read sweep over every address
    for (int a = 0; a < 65536; a++) access(1'b1, 1'b0, 16'(a), 16'h0);
    // R5: write one register at a time, others untouched
    for (int i = 0; i < 4; i++) begin
      access(1'b1, 1'b1, 16'(16'hFE00 + 2 * i), 16'(16'hA0C3 + i * 16'h1111));
      readBack("R5");
    end
    // R1 R3 R6 R9: write sweep over every address
    for (int a = 0; a < 65536; a++) access(1'b1, 1'b1, 16'(a), 16'(a) ^ 16'h5A5A);
    readBack("R5");
    // R2: access disabled, including writes to device addresses
    for (int a = 0; a < 65536; a += 16) access(1'b0, 1'b1, 16'(a), 16'hFFFF);
    for (int i = 0; i < 4; i++) access(1'b0, 1'b1, 16'(16'hFE00 + 2 * i), 16'h1234);
    readBack("R2");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule